// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer that sits between two unrelated clock domains. By default it holds 1024 words of 9 bits. A producer writes words on the write clock and a consumer takes them out in order on the read clock. Pointers cross between the domains as Gray codes through two-stage synchronisers. Four active-low status outputs are provided. The empty flag and the near-empty flag are registered on the read clock. The full flag and the near-full flag are registered on the write clock.

A shared auxiliary write-side pin has one of two roles. The level it holds while reset is asserted selects the role, and the role stays fixed until the next reset. If the pin is held high during reset, it becomes a second write qualifier. If it is held low during reset, it becomes a threshold-access strobe. While the strobe is low, write-clock edges load the near-empty and near-full thresholds in four slices, and read-clock edges return those slices on the data output. The read data is a registered value. A separate drive-enable output tells the pad logic when to drive that value.

Top module: `xcf_fifo`

## Requirements
- R1: While reset is asserted and after it is released, the flags read empty_n=0, full_n=1, near_empty_n=0 and near_full_n=1, and rd_data is 0. Both thresholds return to 7 and both slice indices return to 0.
- R2: The level of wr_aux_i on write- and read-clock edges during reset selects the mode: 1 selects dual-qualifier mode, 0 selects threshold mode. In dual-qualifier mode, wr_aux_i never gives threshold access, so a read with wr_aux_i low is an ordinary FIFO read.
- R3: A word is stored on a rising write-clock edge exactly when wr_en_n_i=0, wr_aux_i=1 and the FIFO is not full. Neither mode stores a word when wr_aux_i=0 or wr_en_n_i=1.
- R4: In threshold mode, a write-clock edge with wr_en_n_i=0 and wr_aux_i=0 loads wr_data_i into a threshold slice and leaves the FIFO contents and fill level unchanged.
- R5: Slices are used in the order index 0 = near-empty bits 8:0, index 1 = near-empty bit 9 (taken from or returned on data bit 0), index 2 = near-full bits 8:0, index 3 = near-full bit 9. Write and read each keep their own index. Each index wraps from 3 to 0 and returns to 0 on reset.
- R6: In threshold mode, a read-clock edge with both read enables 0 and wr_aux_i=0 places the indexed slice on rd_data, zero-extended, and does not advance the FIFO read pointer.
- R7: A word is removed on a rising read-clock edge and appears on rd_data after that edge, exactly when rd_en_a_n_i=0, rd_en_b_n_i=0, the FIFO is not empty, and no threshold read applies. Words leave in the order written.
- R8: After 1024 stored words, full_n goes low. Further write attempts are ignored and lose no stored data.
- R9: empty_n goes low once the last word is read. A read attempt while empty leaves rd_data unchanged.
- R10: near_empty_n is 0 exactly when the fill level seen by the read side is at or below the near-empty threshold.
- R11: near_full_n is 0 exactly when the free space seen by the write side is at or below the near-full threshold.
- R12: rd_data_drv_o equals the inverse of out_en_n_i at all times, and out_en_n_i does not change rd_data.
- R13: rd_data holds its value on every read-clock edge where either read enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_n_i | input | 1 | Active-low reset, asynchronous assertion |
| wr_en_n_i | input | 1 | Active-low write enable |
| wr_aux_i | input | 1 | Second write qualifier or threshold-access strobe (active low), chosen at reset |
| wr_data_i | input | 9 | Write data |
| rd_en_a_n_i | input | 1 | First active-low read enable |
| rd_en_b_n_i | input | 1 | Second active-low read enable |
| out_en_n_i | input | 1 | Active-low output drive enable |
| rd_data_o | output | 9 | Registered read data or threshold slice |
| rd_data_drv_o | output | 1 | High when rd_data_o should be driven |
| empty_n_o | output | 1 | Empty flag, active low, read clock |
| full_n_o | output | 1 | Full flag, active low, write clock |
| near_empty_n_o | output | 1 | Near-empty flag, active low, read clock |
| near_full_n_o | output | 1 | Near-full flag, active low, write clock |

## Verification
The bench fills the buffer to exactly 1024 words and then tries one extra write. A design that ignores the full flag would overwrite the oldest word or leave a stray word after the drain. The level flags are probed one word either side of each threshold, including a near-full threshold above 511 that needs its high slice. An off-by-one comparison shows up there as a flag that switches one word early or late. The slice order and the wrap are checked by reading the slices back, and the reset test confirms that the index restarts. A design that let slice access touch the pointers would show words appearing or going missing. A read with the auxiliary pin low in dual-qualifier mode catches a design that does not honour the mode latched at reset.

// File: rtl/xcf_pkg.sv
`timescale 1ns/1ps
package xcf_pkg;

    // Role of the shared auxiliary pin, captured during reset
    typedef enum logic {
        MODE_THRESH = 1'b0,
        MODE_DUAL   = 1'b1
    } pin_mode_e;

    // Threshold slice order (write and read follow the same order)
    typedef enum logic [1:0] {
        SEL_NE_LO = 2'd0,
        SEL_NE_HI = 2'd1,
        SEL_NF_LO = 2'd2,
        SEL_NF_HI = 2'd3
    } thr_sel_e;

endpackage

// File: rtl/xcf_ptr_sync.sv
`timescale 1ns/1ps
module xcf_ptr_sync #(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_i,
    output logic [PW-1:0] bin_o
);

    typedef struct packed {
        logic [PW-1:0] meta;
        logic [PW-1:0] sync;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = gray_i;
        s_d.sync = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits
    for (genvar gi = 0; gi < PW; gi++) begin : g_bin
        assign bin_o[gi] = ^(s_q.sync >> gi);
    end

endmodule

// File: rtl/xcf_store.sv
`timescale 1ns/1ps
module xcf_store #(
    parameter int DW = 9,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/xcf_wr_side.sv
`timescale 1ns/1ps
module xcf_wr_side
    import xcf_pkg::*;
#(
    parameter int DW      = 9,
    parameter int AW      = 10,
    parameter int THR_RST = 7
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en_n_i,
    input  logic          wr_aux_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW:0]   rbin_sync_i,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_waddr_o,
    output logic [AW:0]   wbin_o,
    output logic [AW:0]   wgray_o,
    output logic          full_n_o,
    output logic          near_full_n_o,
    output logic [AW-1:0] ne_thr_o,
    output logic [AW-1:0] nf_thr_o
);

    localparam int PW    = AW + 1;
    localparam int TW    = AW;
    localparam int DEPTH = 1 << AW;
    localparam int LO_W  = (TW > DW) ? DW : TW - 1;
    localparam int HI_W  = TW - LO_W;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full_n;
        logic          near_full_n;
        logic [TW-1:0] ne_thr;
        logic [TW-1:0] nf_thr;
        thr_sel_e      sel;
    } wr_state_t;

    wr_state_t w_d, w_q;
    pin_mode_e mode_q;

    logic          push;
    logic          thr_wr;
    logic [PW-1:0] used;
    logic [PW-1:0] space;

    always_comb begin
        w_d    = w_q;
        thr_wr = (mode_q == MODE_THRESH) && !wr_en_n_i && !wr_aux_i;
        push   = !wr_en_n_i && wr_aux_i && w_q.full_n;

        if (thr_wr) begin
            case (w_q.sel)
                SEL_NE_LO: w_d.ne_thr[LO_W-1:0]  = wr_data_i[LO_W-1:0];
                SEL_NE_HI: w_d.ne_thr[TW-1:LO_W] = wr_data_i[HI_W-1:0];
                SEL_NF_LO: w_d.nf_thr[LO_W-1:0]  = wr_data_i[LO_W-1:0];
                default:   w_d.nf_thr[TW-1:LO_W] = wr_data_i[HI_W-1:0];
            endcase
            w_d.sel = thr_sel_e'(w_q.sel + 2'd1);
        end

        if (push) begin
            w_d.bin = w_q.bin + PW'(1);
        end
        w_d.gray = w_d.bin ^ (w_d.bin >> 1);

        used          = w_d.bin - rbin_sync_i;
        space         = PW'(DEPTH) - used;
        w_d.full_n      = (used != PW'(DEPTH));
        w_d.near_full_n = (space > PW'(w_d.nf_thr));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.bin         <= '0;
            w_q.gray        <= '0;
            w_q.full_n      <= 1'b1;
            w_q.near_full_n <= (DEPTH > THR_RST);
            w_q.ne_thr      <= TW'(THR_RST);
            w_q.nf_thr      <= TW'(THR_RST);
            w_q.sel         <= SEL_NE_LO;
        end else begin
            w_q <= w_d;
        end
    end

    // Pin role is captured on every write-clock edge seen during reset
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            mode_q <= pin_mode_e'(wr_aux_i);
        end
    end

    assign mem_we_o      = push;
    assign mem_waddr_o   = w_q.bin[AW-1:0];
    assign wbin_o        = w_q.bin;
    assign wgray_o       = w_q.gray;
    assign full_n_o      = w_q.full_n;
    assign near_full_n_o = w_q.near_full_n;
    assign ne_thr_o      = w_q.ne_thr;
    assign nf_thr_o      = w_q.nf_thr;

endmodule

// File: rtl/xcf_rd_side.sv
`timescale 1ns/1ps
module xcf_rd_side
    import xcf_pkg::*;
#(
    parameter int DW = 9,
    parameter int AW = 10
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en_a_n_i,
    input  logic          rd_en_b_n_i,
    input  logic          wr_aux_i,
    input  logic [AW:0]   wbin_sync_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic [AW-1:0] ne_thr_i,
    input  logic [AW-1:0] nf_thr_i,
    output logic [AW-1:0] mem_raddr_o,
    output logic [AW:0]   rbin_o,
    output logic [AW:0]   rgray_o,
    output logic          empty_n_o,
    output logic          near_empty_n_o,
    output logic [DW-1:0] rd_data_o
);

    localparam int PW   = AW + 1;
    localparam int TW   = AW;
    localparam int LO_W = (TW > DW) ? DW : TW - 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty_n;
        logic          near_empty_n;
        logic [DW-1:0] data;
        thr_sel_e      sel;
    } rd_state_t;

    rd_state_t r_d, r_q;
    pin_mode_e mode_q;

    logic          pop;
    logic          thr_rd;
    logic [PW-1:0] fill;

    always_comb begin
        r_d    = r_q;
        thr_rd = (mode_q == MODE_THRESH) && !rd_en_a_n_i && !rd_en_b_n_i && !wr_aux_i;
        pop    = !rd_en_a_n_i && !rd_en_b_n_i && r_q.empty_n && !thr_rd;

        if (thr_rd) begin
            case (r_q.sel)
                SEL_NE_LO: r_d.data = DW'(ne_thr_i[LO_W-1:0]);
                SEL_NE_HI: r_d.data = DW'(ne_thr_i[TW-1:LO_W]);
                SEL_NF_LO: r_d.data = DW'(nf_thr_i[LO_W-1:0]);
                default:   r_d.data = DW'(nf_thr_i[TW-1:LO_W]);
            endcase
            r_d.sel = thr_sel_e'(r_q.sel + 2'd1);
        end else if (pop) begin
            r_d.data = mem_rdata_i;
            r_d.bin  = r_q.bin + PW'(1);
        end
        r_d.gray = r_d.bin ^ (r_d.bin >> 1);

        fill             = wbin_sync_i - r_d.bin;
        r_d.empty_n      = (fill != '0);
        r_d.near_empty_n = (fill > PW'(ne_thr_i));
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.bin          <= '0;
            r_q.gray         <= '0;
            r_q.empty_n      <= 1'b0;
            r_q.near_empty_n <= 1'b0;
            r_q.data         <= '0;
            r_q.sel          <= SEL_NE_LO;
        end else begin
            r_q <= r_d;
        end
    end

    // Read side keeps its own copy of the pin role, captured during reset
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            mode_q <= pin_mode_e'(wr_aux_i);
        end
    end

    assign mem_raddr_o    = r_q.bin[AW-1:0];
    assign rbin_o         = r_q.bin;
    assign rgray_o        = r_q.gray;
    assign empty_n_o      = r_q.empty_n;
    assign near_empty_n_o = r_q.near_empty_n;
    assign rd_data_o      = r_q.data;

endmodule

// File: rtl/xcf_fifo.sv
`timescale 1ns/1ps
module xcf_fifo #(
    parameter int DW      = 9,
    parameter int AW      = 10,
    parameter int THR_RST = 7
) (
    input  logic          wclk_i,
    input  logic          rclk_i,
    input  logic          rst_n_i,
    input  logic          wr_en_n_i,
    input  logic          wr_aux_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_a_n_i,
    input  logic          rd_en_b_n_i,
    input  logic          out_en_n_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_data_drv_o,
    output logic          empty_n_o,
    output logic          full_n_o,
    output logic          near_empty_n_o,
    output logic          near_full_n_o
);

    localparam int PW = AW + 1;

    logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PW-1:0] wr_bin_in_rd, rd_bin_in_wr;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] ne_thr, nf_thr;

    xcf_wr_side #(.DW(DW), .AW(AW), .THR_RST(THR_RST)) u_wr (
        .wclk          (wclk_i),
        .rst_n         (rst_n_i),
        .wr_en_n_i     (wr_en_n_i),
        .wr_aux_i      (wr_aux_i),
        .wr_data_i     (wr_data_i),
        .rbin_sync_i   (rd_bin_in_wr),
        .mem_we_o      (mem_we),
        .mem_waddr_o   (mem_waddr),
        .wbin_o        (wr_bin),
        .wgray_o       (wr_gray),
        .full_n_o      (full_n_o),
        .near_full_n_o (near_full_n_o),
        .ne_thr_o      (ne_thr),
        .nf_thr_o      (nf_thr)
    );

    xcf_ptr_sync #(.PW(PW)) u_sync_w2r (
        .clk    (rclk_i),
        .rst_n  (rst_n_i),
        .gray_i (wr_gray),
        .bin_o  (wr_bin_in_rd)
    );

    xcf_ptr_sync #(.PW(PW)) u_sync_r2w (
        .clk    (wclk_i),
        .rst_n  (rst_n_i),
        .gray_i (rd_gray),
        .bin_o  (rd_bin_in_wr)
    );

    xcf_store #(.DW(DW), .AW(AW)) u_store (
        .wclk    (wclk_i),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (wr_data_i),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    xcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .rclk           (rclk_i),
        .rst_n          (rst_n_i),
        .rd_en_a_n_i    (rd_en_a_n_i),
        .rd_en_b_n_i    (rd_en_b_n_i),
        .wr_aux_i       (wr_aux_i),
        .wbin_sync_i    (wr_bin_in_rd),
        .mem_rdata_i    (mem_rdata),
        .ne_thr_i       (ne_thr),
        .nf_thr_i       (nf_thr),
        .mem_raddr_o    (mem_raddr),
        .rbin_o         (rd_bin),
        .rgray_o        (rd_gray),
        .empty_n_o      (empty_n_o),
        .near_empty_n_o (near_empty_n_o),
        .rd_data_o      (rd_data_o)
    );

    assign rd_data_drv_o = !out_en_n_i;

endmodule

// File: rtl/xcf_fifo_chk.sv
`timescale 1ns/1ps
module xcf_fifo_chk #(
    parameter int DW = 9,
    parameter int PW = 11
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          wr_aux,
    input logic          rd_en_a_n,
    input logic          rd_en_b_n,
    input logic          full_n,
    input logic          empty_n,
    input logic          near_full_n,
    input logic          near_empty_n,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] rd_bin,
    input logic [PW-1:0] wr_gray,
    input logic [PW-1:0] rd_gray
);

    // R8
    full_block_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !wr_en_n && wr_aux) |=> $stable(wr_bin));

    // R9
    empty_block_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && !rd_en_a_n && !rd_en_b_n) |=> $stable(rd_bin));

    // R13
    data_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en_a_n || rd_en_b_n) |=> $stable(rd_data));

    // R10
    empty_near_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !near_empty_n);

    // R11
    full_near_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !near_full_n);

    // R3
    wr_gray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

    // R7
    rd_gray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        1'b1 |=> ($countones(rd_gray ^ $past(rd_gray)) <= 1));

endmodule

bind xcf_fifo xcf_fifo_chk #(.DW(DW), .PW(PW)) chk_i (
    .wclk         (wclk_i),
    .rclk         (rclk_i),
    .rst_n        (rst_n_i),
    .wr_en_n      (wr_en_n_i),
    .wr_aux       (wr_aux_i),
    .rd_en_a_n    (rd_en_a_n_i),
    .rd_en_b_n    (rd_en_b_n_i),
    .full_n       (full_n_o),
    .empty_n      (empty_n_o),
    .near_full_n  (near_full_n_o),
    .near_empty_n (near_empty_n_o),
    .rd_data      (rd_data_o),
    .wr_bin       (wr_bin),
    .rd_bin       (rd_bin),
    .wr_gray      (wr_gray),
    .rd_gray      (rd_gray)
);

// File: tb/xcf_fifo_test.sv
`timescale 1ns/1ps
module xcf_fifo_test;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       wr_aux = 1'b1;
    logic [8:0] wr_data = '0;
    logic       rd_a_n = 1'b1;
    logic       rd_b_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [8:0] rd_data;
    logic       drv, empty_n, full_n, near_empty_n, near_full_n;

    int n_chk = 0;
    int n_pass = 0;

    always #2.5 wclk = ~wclk;   // 200 MHz write clock
    always #3.5 rclk = ~rclk;

    xcf_fifo uut (
        .wclk_i         (wclk),
        .rclk_i         (rclk),
        .rst_n_i        (rst_n),
        .wr_en_n_i      (wr_en_n),
        .wr_aux_i       (wr_aux),
        .wr_data_i      (wr_data),
        .rd_en_a_n_i    (rd_a_n),
        .rd_en_b_n_i    (rd_b_n),
        .out_en_n_i     (oe_n),
        .rd_data_o      (rd_data),
        .rd_data_drv_o  (drv),
        .empty_n_o      (empty_n),
        .full_n_o       (full_n),
        .near_empty_n_o (near_empty_n),
        .near_full_n_o  (near_full_n)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act == exp) n_pass++;
        else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    endtask

    task automatic do_reset(input logic aux_level);
        rst_n = 1'b0;
        wr_aux = aux_level;
        wr_en_n = 1'b1;
        rd_a_n = 1'b1;
        rd_b_n = 1'b1;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        wr_aux = 1'b1;
        repeat (4) @(negedge rclk);
    endtask

    task automatic wr_cycle(input logic en_n, input logic aux, input logic [8:0] d);
        @(negedge wclk);
        wr_en_n = en_n;
        wr_aux = aux;
        wr_data = d;
        @(negedge wclk);
        wr_en_n = 1'b1;
        wr_aux = 1'b1;
    endtask

    task automatic rd_cycle(input logic a_n, input logic b_n, input logic aux);
        @(negedge rclk);
        rd_a_n = a_n;
        rd_b_n = b_n;
        wr_aux = aux;
        @(negedge rclk);
        rd_a_n = 1'b1;
        rd_b_n = 1'b1;
        wr_aux = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic test_reset_state();
        do_reset(1'b1);
        check_eq("R1 empty_n after reset", int'(empty_n), 0);
        check_eq("R1 full_n after reset", int'(full_n), 1);
        check_eq("R1 near_empty_n after reset", int'(near_empty_n), 0);
        check_eq("R1 near_full_n after reset", int'(near_full_n), 1);
        check_eq("R1 rd_data after reset", int'(rd_data), 0);
    endtask

    task automatic test_dual_mode();
        do_reset(1'b1);
        wr_cycle(1'b0, 1'b0, 9'h011);   // second qualifier low: no store
        wr_cycle(1'b1, 1'b1, 9'h022);   // first enable high: no store
        settle();
        check_eq("R3 gated writes leave FIFO empty", int'(empty_n), 0);
        wr_cycle(1'b0, 1'b1, 9'h0A5);
        wr_cycle(1'b0, 1'b1, 9'h15A);
        wr_cycle(1'b0, 1'b1, 9'h1FF);
        settle();
        check_eq("R3 qualified writes stored", int'(empty_n), 1);
        check_eq("R10 three words below threshold 7", int'(near_empty_n), 0);
        rd_cycle(1'b0, 1'b0, 1'b0);     // aux low in dual mode is a plain read
        check_eq("R2 dual mode read with aux low", int'(rd_data), 9'h0A5);
        rd_cycle(1'b0, 1'b1, 1'b1);
        check_eq("R13 one read enable high holds data", int'(rd_data), 9'h0A5);
        rd_cycle(1'b1, 1'b0, 1'b1);
        check_eq("R13 other read enable high holds data", int'(rd_data), 9'h0A5);
        rd_cycle(1'b0, 1'b0, 1'b1);
        check_eq("R7 second word in order", int'(rd_data), 9'h15A);
        rd_cycle(1'b0, 1'b0, 1'b1);
        check_eq("R7 third word in order", int'(rd_data), 9'h1FF);
        settle();
        check_eq("R9 empty after last read", int'(empty_n), 0);
        rd_cycle(1'b0, 1'b0, 1'b1);
        check_eq("R9 read on empty keeps data", int'(rd_data), 9'h1FF);
    endtask

    task automatic test_fill_drain();
        do_reset(1'b1);
        for (int n = 1; n <= 1024; n++) begin
            wr_cycle(1'b0, 1'b1, 9'((n * 5) % 512));
            if (n == 1016) check_eq("R11 free 8 above threshold", int'(near_full_n), 1);
            if (n == 1017) check_eq("R11 free 7 at threshold", int'(near_full_n), 0);
            if (n == 1023) check_eq("R8 not full at 1023", int'(full_n), 1);
        end
        check_eq("R8 full at 1024", int'(full_n), 0);
        wr_cycle(1'b0, 1'b1, 9'h1EE);   // must be ignored
        check_eq("R8 still full after extra write", int'(full_n), 0);
        settle();
        check_eq("R10 full buffer above threshold", int'(near_empty_n), 1);
        for (int r = 1; r <= 1024; r++) begin
            rd_cycle(1'b0, 1'b0, 1'b1);
            check_eq("R7 drain order", int'(rd_data), (r * 5) % 512);
            if (1024 - r == 8) check_eq("R10 fill 8 above threshold", int'(near_empty_n), 1);
            if (1024 - r == 7) check_eq("R10 fill 7 at threshold", int'(near_empty_n), 0);
        end
        settle();
        check_eq("R8 extra write left nothing behind", int'(empty_n), 0);
        check_eq("R8 full cleared after drain", int'(full_n), 1);
    endtask

    task automatic test_threshold_mode();
        do_reset(1'b0);
        // near-empty threshold 3, near-full threshold 600 (= 88 + 512)
        wr_cycle(1'b0, 1'b0, 9'd3);
        wr_cycle(1'b0, 1'b0, 9'd0);
        wr_cycle(1'b0, 1'b0, 9'd88);
        wr_cycle(1'b0, 1'b0, 9'd1);
        settle();
        check_eq("R4 slice loads leave FIFO empty", int'(empty_n), 0);
        check_eq("R4 slice loads leave full_n high", int'(full_n), 1);
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R6 slice 0 readback", int'(rd_data), 3);
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R6 slice 1 readback", int'(rd_data), 0);
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R5 slice 2 readback", int'(rd_data), 88);
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R5 slice 3 readback", int'(rd_data), 1);
        wr_cycle(1'b0, 1'b0, 9'd4);     // write index wrapped: near-empty low part
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R5 wrapped slice 0", int'(rd_data), 4);
        for (int n = 1; n <= 424; n++) begin
            wr_cycle(1'b0, 1'b1, 9'(n));
            if (n == 4) begin
                settle();
                check_eq("R10 fill 4 at threshold 4", int'(near_empty_n), 0);
            end
            if (n == 5) begin
                settle();
                check_eq("R10 fill 5 above threshold 4", int'(near_empty_n), 1);
            end
            if (n == 423) check_eq("R11 free 601 above threshold 600", int'(near_full_n), 1);
            if (n == 424) check_eq("R11 free 600 at threshold 600", int'(near_full_n), 0);
        end
        settle();
        rd_cycle(1'b0, 1'b0, 1'b1);
        check_eq("R7 FIFO read in threshold mode", int'(rd_data), 1);
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R6 slice 1 after wrap", int'(rd_data), 0);
        rd_cycle(1'b0, 1'b0, 1'b1);
        check_eq("R6 slice read did not pop", int'(rd_data), 2);
    endtask

    task automatic test_reset_restart();
        do_reset(1'b0);
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R5 index restarts, R1 near-empty default", int'(rd_data), 7);
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R1 near-empty default high slice", int'(rd_data), 0);
        rd_cycle(1'b0, 1'b0, 1'b0);
        check_eq("R1 near-full default", int'(rd_data), 7);
    endtask

    task automatic test_drive();
        logic [8:0] held;
        held = rd_data;
        oe_n = 1'b1;
        #1;
        check_eq("R12 drive off", int'(drv), 0);
        check_eq("R12 data kept while undriven", int'(rd_data), int'(held));
        oe_n = 1'b0;
        #1;
        check_eq("R12 drive on", int'(drv), 1);
    endtask

    initial begin
        #900000;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_pass, n_chk);
        $finish;
    end

    initial begin
        test_reset_state();
        test_dual_mode();
        test_fill_drain();
        test_threshold_mode();
        test_reset_restart();
        test_drive();
        $display("%0d/%0d checks passed", n_pass, n_chk);
        $finish;
    end

endmodule